// File: doc/BRIEF.md
# Asynchronous SRAM Write-Cycle Sequencer

This block is a clocked controller that performs single write cycles on an asynchronous static RAM by driving the RAM's control pins. A host presents a request together with an address and a data word. The block accepts the request only while it is idle. It then runs a fixed sequence of phases: address setup, write strobe and write recovery. When recovery has finished it raises a one-cycle completion pulse. The chip enable, write enable and output enable outputs are all active low and registered. The data bus is delivered as a value plus a separate driver-enable, so that the tri-state buffer can sit in the pad ring.

Two strobe styles are available and are chosen per request. In write-enable-strobed mode the chip enable falls first and the write enable opens and closes the write. In enable-strobed mode the write enable falls first and the chip enable opens and closes the write. A configuration input asks for the RAM's output enable to be held low during the cycle. When that option is set in write-enable-strobed mode, the RAM may still be driving the bus when the strobe opens. The block therefore keeps its own driver off for a turn-off window and lengthens the strobe so that the full data-setup time still fits after that window. Every timing value is an elaboration parameter counted in clock cycles, with a minimum of one cycle.

Top module: `sram_wr_seq`

## Requirements
- R1: Address and data are captured from the request inputs in the cycle the request is accepted. `mem_addr` and `mem_dout` hold those values for the whole cycle. `mem_addr` never changes while `mem_ce_n` and `mem_we_n` are both low.
- R2: With `wr_mode` = 0 (write-enable strobed), `mem_ce_n` goes low at acceptance while `mem_we_n` stays high for T_AS cycles. At the end of the strobe `mem_we_n` returns high first, and `mem_ce_n` stays low through recovery.
- R3: With `wr_mode` = 1 (enable strobed), `mem_we_n` goes low at acceptance while `mem_ce_n` stays high for T_AS cycles. At the end of the strobe `mem_ce_n` returns high first, and `mem_we_n` stays low through recovery.
- R4: The overlap in which both strobes are low lasts max(T_WP, T_DW) cycles. In write-enable-strobed mode with `cfg_oe_low` = 1 it lasts max(T_WP, T_WZ + T_DW) cycles.
- R5: In write-enable-strobed mode with `cfg_oe_low` = 1, `mem_doe` stays low for the first T_WZ overlap cycles and is high for the rest of the overlap. In every other case `mem_doe` is high for the whole overlap. In both cases `mem_doe` stays high for T_DH cycles after the overlap and then goes low. `mem_dout` does not change while `mem_doe` is high.
- R6: After the overlap ends, recovery lasts max(T_WR, T_DH) cycles before the cycle completes.
- R7: `done` is high for exactly one cycle, in the cycle after recovery. In that cycle `busy` is low. A request present in that cycle is accepted at once, and `busy` is high in the next cycle.
- R8: While `busy` is high, `req`, `req_addr`, `req_data`, `wr_mode` and `cfg_oe_low` are ignored.
- R9: During a cycle, `mem_oe_n` equals the inverse of `cfg_oe_low` as sampled at acceptance. It is high while the block is idle.
- R10: After reset, and whenever the block is idle, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are high and `mem_doe`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Write request, accepted only when idle |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| wr_mode | input | 1 | 0 = write-enable strobed, 1 = enable strobed |
| cfg_oe_low | input | 1 | 1 = hold RAM output enable low during the cycle |
| busy | output | 1 | A write cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | AW | RAM address |
| mem_dout | output | DW | RAM write data |
| mem_doe | output | 1 | Data bus driver enable |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |

## Verification
A wrong phase state or phase counter appears at the pins within the same write cycle. It shows up as a setup, overlap or recovery phase of the wrong length, or as the strobes falling or rising in the wrong order. So one transaction of each mode and output-enable combination is enough to reveal it. A mode or output-enable flag latched at the wrong time shows up as a strobe of the wrong length or a driver window in the wrong place within a few cycles. Writing input values into the capture registers while busy shows up as `mem_addr` or `mem_dout` moving within the cycle in which the inputs change.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ASU  = 2'd1,
    ST_STB  = 2'd2,
    ST_REC  = 2'd3
  } wr_state_e;

  function automatic int umax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d
);

  // cycles spent in the current phase, saturating
  always_comb begin
    if (restart)      cnt_d = '0;
    else if (&cnt_q)  cnt_d = cnt_q;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
  import sram_wr_pkg::*;
#(
  parameter int CW     = 4,
  parameter int T_AS   = 1,
  parameter int P_NORM = 1,
  parameter int P_SLOW = 1,
  parameter int T_REC  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          wr_mode,
  input  logic          cfg_oe_low,
  input  logic [CW-1:0] cnt_q,
  output wr_state_e     state_q,
  output wr_state_e     state_d,
  output logic          restart,
  output logic          accept,
  output logic          mode_q,
  output logic          oe_low_q
);

  logic [CW-1:0] len_m1;
  logic          last;

  // phase length minus one, chosen from the latched request options
  always_comb begin
    unique case (state_q)
      ST_ASU:  len_m1 = CW'(T_AS - 1);
      ST_STB:  len_m1 = (!mode_q && oe_low_q) ? CW'(P_SLOW - 1) : CW'(P_NORM - 1);
      ST_REC:  len_m1 = CW'(T_REC - 1);
      default: len_m1 = '0;
    endcase
  end

  assign last   = (cnt_q == len_m1);
  assign accept = (state_q == ST_IDLE) && req;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req)  state_d = ST_ASU;
      ST_ASU:  if (last) state_d = ST_STB;
      ST_STB:  if (last) state_d = ST_REC;
      ST_REC:  if (last) state_d = ST_IDLE;
      default:           state_d = ST_IDLE;
    endcase
  end

  assign restart = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      mode_q   <= 1'b0;
      oe_low_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        mode_q   <= wr_mode;
        oe_low_q <= cfg_oe_low;
      end
    end
  end

endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int AW   = 11,
  parameter int DW   = 9,
  parameter int CW   = 4,
  parameter int T_WZ = 1,
  parameter int T_DH = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          wr_mode,
  input  logic          cfg_oe_low,
  input  logic          mode_q,
  input  logic          oe_low_q,
  input  wr_state_e     state_q,
  input  wr_state_e     state_d,
  input  logic [CW-1:0] cnt_d,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic          mem_doe,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n
);

  logic mode_n, oel_n, gap_n;

  // options of the cycle being entered or run
  assign mode_n = accept ? wr_mode    : mode_q;
  assign oel_n  = accept ? cfg_oe_low : oe_low_q;
  assign gap_n  = !mode_n && oel_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      mem_addr <= '0;
      mem_dout <= '0;
      mem_doe  <= 1'b0;
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_oe_n <= 1'b1;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        mem_dout <= req_data;
      end
      busy <= (state_d != ST_IDLE);
      done <= (state_q == ST_REC) && (state_d == ST_IDLE);
      unique case (state_d)
        ST_ASU: begin
          mem_ce_n <= mode_n;
          mem_we_n <= !mode_n;
          mem_doe  <= 1'b0;
          mem_oe_n <= !oel_n;
        end
        ST_STB: begin
          mem_ce_n <= 1'b0;
          mem_we_n <= 1'b0;
          mem_doe  <= !gap_n || (cnt_d >= CW'(T_WZ));
          mem_oe_n <= !oel_n;
        end
        ST_REC: begin
          mem_ce_n <= mode_n;
          mem_we_n <= !mode_n;
          mem_doe  <= (cnt_d < CW'(T_DH));
          mem_oe_n <= !oel_n;
        end
        default: begin
          mem_ce_n <= 1'b1;
          mem_we_n <= 1'b1;
          mem_doe  <= 1'b0;
          mem_oe_n <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int AW   = 11,
  parameter int DW   = 9,
  parameter int T_AS = 2,
  parameter int T_WP = 3,
  parameter int T_WR = 2,
  parameter int T_DW = 2,
  parameter int T_DH = 1,
  parameter int T_WZ = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          wr_mode,
  input  logic          cfg_oe_low,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic          mem_doe,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n
);

  localparam int P_NORM = umax(T_WP, T_DW);
  localparam int P_SLOW = umax(T_WP, T_WZ + T_DW);
  localparam int T_REC  = umax(T_WR, T_DH);
  localparam int MAXLEN = umax(umax(T_AS, P_SLOW), T_REC);
  localparam int CW     = umax($clog2(MAXLEN + 1), 1);

  wr_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          restart, accept, mode_q, oe_low_q;

  sram_wr_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .cnt_q   (cnt_q),
    .cnt_d   (cnt_d)
  );

  sram_wr_fsm #(
    .CW(CW), .T_AS(T_AS), .P_NORM(P_NORM), .P_SLOW(P_SLOW), .T_REC(T_REC)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .wr_mode    (wr_mode),
    .cfg_oe_low (cfg_oe_low),
    .cnt_q      (cnt_q),
    .state_q    (state_q),
    .state_d    (state_d),
    .restart    (restart),
    .accept     (accept),
    .mode_q     (mode_q),
    .oe_low_q   (oe_low_q)
  );

  sram_wr_pins #(
    .AW(AW), .DW(DW), .CW(CW), .T_WZ(T_WZ), .T_DH(T_DH)
  ) u_pins (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .wr_mode    (wr_mode),
    .cfg_oe_low (cfg_oe_low),
    .mode_q     (mode_q),
    .oe_low_q   (oe_low_q),
    .state_q    (state_q),
    .state_d    (state_d),
    .cnt_d      (cnt_d),
    .busy       (busy),
    .done       (done),
    .mem_addr   (mem_addr),
    .mem_dout   (mem_dout),
    .mem_doe    (mem_doe),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n)
  );

endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk #(
  parameter int AW = 11,
  parameter int DW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          mode_q,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dout,
  input logic          mem_doe,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n
);

  p_addr_frozen_r1: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !mem_we_n) |=> $stable(mem_addr));

  p_ce_first_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && !mode_q) |-> (!mem_ce_n && mem_we_n));

  p_we_first_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && mode_q) |-> (mem_ce_n && !mem_we_n));

  p_data_steady_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_doe && $past(mem_doe)) |-> $stable(mem_dout));

  p_drive_in_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    mem_doe |-> busy);

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_oe_fixed_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mem_oe_n));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_doe));

endmodule

bind sram_wr_seq sram_wr_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .mode_q   (mode_q),
  .mem_addr (mem_addr),
  .mem_dout (mem_dout),
  .mem_doe  (mem_doe),
  .mem_ce_n (mem_ce_n),
  .mem_we_n (mem_we_n),
  .mem_oe_n (mem_oe_n)
);

// File: tb/sram_wr_seq_test.sv
module sram_wr_seq_test;

  localparam int TP   = 10;
  localparam int AW   = 11;
  localparam int DW   = 9;
  localparam int T_AS = 2;
  localparam int T_WP = 3;
  localparam int T_WR = 2;
  localparam int T_DW = 2;
  localparam int T_DH = 1;
  localparam int T_WZ = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          wr_mode = 1'b0;
  logic          cfg_oe_low = 1'b0;
  logic          busy, done, mem_doe, mem_ce_n, mem_we_n, mem_oe_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dout;

  int total = 0;
  int bad   = 0;
  int unsigned seed_val;

  always #(TP/2) clk = ~clk;

  sram_wr_seq #(
    .AW(AW), .DW(DW), .T_AS(T_AS), .T_WP(T_WP), .T_WR(T_WR),
    .T_DW(T_DW), .T_DH(T_DH), .T_WZ(T_WZ)
  ) uut (
    .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .req_data(req_data),
    .wr_mode(wr_mode), .cfg_oe_low(cfg_oe_low), .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int exp_pulse(input logic m, input logic oel);
    return (!m && oel) ? mx(T_WP, T_WZ + T_DW) : mx(T_WP, T_DW);
  endfunction

  function automatic int exp_drive(input logic m, input logic oel);
    return (!m && oel) ? exp_pulse(m, oel) - T_WZ : exp_pulse(m, oel);
  endfunction

  function automatic int exp_rec();
    return mx(T_WR, T_DH);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic scramble();
    req        = 1'($urandom);
    req_addr   = AW'($urandom);
    req_data   = DW'($urandom);
    wr_mode    = 1'($urandom);
    cfg_oe_low = 1'($urandom);
  endtask

  // one write; no_wait = already at the negedge where done is visible
  task automatic run_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic m, input logic oel,
                        input bit chain, input bit no_wait);
    int n_asu = 0, n_stb = 0, n_rec = 0, n_dstb = 0, n_drec = 0;
    int bad_a = 0, bad_d = 0, bad_oe = 0, n = 0;
    bit seen = 0;
    if (!no_wait) @(negedge clk);
    req = 1'b1; req_addr = a; req_data = d; wr_mode = m; cfg_oe_low = oel;
    @(negedge clk);
    chk(busy == 1'b1, "R7 accepted on request", int'(busy), 1);
    if (m)
      chk(mem_ce_n && !mem_we_n, "R3 write enable falls first", {mem_ce_n, mem_we_n}, 2);
    else
      chk(!mem_ce_n && mem_we_n, "R2 chip enable falls first", {mem_ce_n, mem_we_n}, 1);
    scramble();
    while (!done && n < 200) begin
      if (mem_addr != a) bad_a++;
      if (mem_doe && mem_dout != d) bad_d++;
      if (mem_oe_n != !oel) bad_oe++;
      if (!mem_ce_n && !mem_we_n) begin
        n_stb++; seen = 1;
        if (mem_doe) n_dstb++;
      end else if (!seen) begin
        n_asu++;
      end else begin
        n_rec++;
        if (mem_doe) n_drec++;
        if (m) begin
          if (!(mem_ce_n && !mem_we_n)) bad_oe += 1000;
        end else begin
          if (!(!mem_ce_n && mem_we_n)) bad_oe += 1000;
        end
      end
      scramble();
      @(negedge clk);
      n++;
    end
    chk(n < 200, "R7 cycle completes", n, 0);
    chk(n_asu == T_AS, m ? "R3 setup length" : "R2 setup length", n_asu, T_AS);
    chk(n_stb == exp_pulse(m, oel), "R4 overlap length", n_stb, exp_pulse(m, oel));
    chk(n_dstb == exp_drive(m, oel), "R5 driver cycles in overlap", n_dstb, exp_drive(m, oel));
    chk(n_drec == T_DH, "R5 data hold cycles", n_drec, T_DH);
    chk(n_rec == exp_rec(), "R6 recovery length", n_rec, exp_rec());
    chk(bad_a == 0, "R1 address stable and captured", bad_a, 0);
    chk(bad_d == 0, "R8 data unaffected by busy inputs", bad_d, 0);
    chk(bad_oe == 0, "R9 oe pin and recovery strobe order", bad_oe, 0);
    chk(done && !busy && mem_ce_n && mem_we_n && !mem_doe, "R7 done with idle pins",
        {done, busy, mem_ce_n, mem_we_n, mem_doe}, 5'b10110);
    if (!chain) begin
      req = 1'b0;
      @(negedge clk);
      chk(!done && !busy, "R7 done lasts one cycle", {done, busy}, 0);
      chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_doe, "R10 idle pins",
          {mem_ce_n, mem_we_n, mem_oe_n, mem_doe}, 4'b1110);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    bit prev_chain;
    seed_val = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_doe && !busy && !done,
        "R10 reset state", {mem_ce_n, mem_we_n, mem_oe_n, mem_doe, busy, done}, 6'b111000);

    // directed: each mode with and without output enable held low
    run_wr(11'h000, 9'h1A5, 1'b0, 1'b0, 0, 0);
    run_wr(11'h7FF, 9'h0FF, 1'b0, 1'b1, 0, 0);
    run_wr(11'h155, 9'h100, 1'b1, 1'b0, 0, 0);
    run_wr(11'h2AA, 9'h1FF, 1'b1, 1'b1, 0, 0);
    // back-to-back across modes
    run_wr(11'h001, 9'h001, 1'b0, 1'b1, 1, 0);
    run_wr(11'h002, 9'h002, 1'b1, 1'b1, 1, 1);
    run_wr(11'h003, 9'h003, 1'b0, 1'b0, 0, 1);

    // random mix with random chaining
    prev_chain = 0;
    for (int i = 0; i < 60; i++) begin
      bit c;
      c = (i == 59) ? 1'b0 : 1'($urandom);
      run_wr(AW'($urandom), DW'($urandom), 1'($urandom), 1'($urandom), c, prev_chain);
      prev_chain = c;
    end

    repeat (4) @(negedge clk);
    chk(!busy && mem_ce_n && mem_we_n, "R10 idle after traffic", {busy, mem_ce_n, mem_we_n}, 3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule